// File: doc/BRIEF.md
# Two-Level Look-Ahead Adder

This block adds two 32-bit operands and a carry-in in one combinational path. The operands are cut into four 8-bit slices. Each slice computes bit-level generate and propagate terms and forms its own internal carries as flattened look-ahead expressions driven by the carry entering the slice. From these terms it derives its sum bits, one group generate and one group propagate.

A second look-ahead unit takes the four group generate/propagate pairs and the external carry-in. It computes every slice-boundary carry directly, each one in flattened sum-of-products form, so no carry passes from one slice to the next. The carry leaving the top slice is the adder's carry-out.

The three internal boundary carries (into bits 8, 16 and 24) are also driven onto a port. Surrounding logic and the testbench can observe them there.

Top module: `lah_adder`

## Requirements
- R1: `sum` equals (`op_a` + `op_b` + `carry_in`) modulo 2^32 for every input combination.
- R2: `carry_out` equals bit 32 of the 33-bit value `op_a` + `op_b` + `carry_in`.
- R3: `seam_carry[k]` (k = 0, 1, 2) equals the carry into bit 8·(k+1). This is bit 8·(k+1) of the sum of the low 8·(k+1) bits of both operands plus `carry_in`.
- R4: The adder has no storage. Every output reflects the current inputs with no clock edge in between.
- R5: When `op_a` XOR `op_b` is all ones and `carry_in` is 1, `sum` is 0, `carry_out` is 1 and all three `seam_carry` bits are 1.
- R6: With `op_a` = `op_b` = 32'h8000_0000 and `carry_in` = 0 (a generate in the top bit only), `sum` is 0, `carry_out` is 1 and `seam_carry` is 3'b000.
- R7: With all inputs zero, `sum`, `carry_out` and `seam_carry` are all zero.
- R8: When every bit of a slice propagates, the carry leaving that slice equals the carry entering it.
- R9: When a slice generates on its own (its group generate is 1), the carry leaving it is 1 whatever carry enters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 32 | Low 32 bits of the sum |
| carry_out | output | 1 | Carry out of bit 31 |
| seam_carry | output | 3 | Carries into bits 8, 16 and 24; bit 0 is the carry into bit 8 |

## Verification
Every result of this adder is due in the same cycle as its stimulus: zero clock edges separate inputs from `sum`, `carry_out` and `seam_carry`. The bench changes the operands on the falling edge and samples all outputs one nanosecond later, well before the next rising edge. Each sample therefore sees only the settled combinational response to the vector just applied. The sweep covers every combination of four slice behaviours (kill, full propagate, top-bit generate, mixed) across the four slices under both carry-in values. Random vectors and the named directed cases follow it.

// File: rtl/lah_pkg.sv
package lah_pkg;

  localparam int unsigned LA_MAXW = 64;

  // Carry into position idx, flattened: OR over j<idx of (g[j] AND p[j+1..idx-1]),
  // plus cin AND p[0..idx-1].
  function automatic logic la_carry(input logic [LA_MAXW-1:0] g,
                                    input logic [LA_MAXW-1:0] p,
                                    input logic               cin,
                                    input int unsigned        idx);
    logic acc;
    logic term;
    logic chain;
    acc = 1'b0;
    for (int unsigned j = 0; j < LA_MAXW; j++) begin
      if (j < idx) begin
        term = g[j];
        for (int unsigned m = 0; m < LA_MAXW; m++) begin
          if (m > j && m < idx) term = term & p[m];
        end
        acc = acc | term;
      end
    end
    chain = cin;
    for (int unsigned m = 0; m < LA_MAXW; m++) begin
      if (m < idx) chain = chain & p[m];
    end
    return acc | chain;
  endfunction

  function automatic logic bit_gen(input logic x, input logic y);
    return x & y;
  endfunction

  function automatic logic bit_prop(input logic x, input logic y);
    return x ^ y;
  endfunction

endpackage

// File: rtl/lah_bitpg.sv
module lah_bitpg #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] g,
  output logic [W-1:0] p
);
  import lah_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign g[i] = bit_gen(x[i], y[i]);
    assign p[i] = bit_prop(x[i], y[i]);
  end

endmodule

// File: rtl/lah_block.sv
module lah_block #(
  parameter int unsigned BW = 8
) (
  input  logic [BW-1:0] x,
  input  logic [BW-1:0] y,
  input  logic          cin,
  output logic [BW-1:0] s,
  output logic          grp_g,
  output logic          grp_p
);
  import lah_pkg::*;

  localparam int unsigned PADW = LA_MAXW - BW;

  logic [BW-1:0]      bg;
  logic [BW-1:0]      bp;
  logic [BW-1:0]      bc;
  logic [LA_MAXW-1:0] bg_wide;
  logic [LA_MAXW-1:0] bp_wide;

  lah_bitpg #(.W(BW)) u_pg (
    .x (x),
    .y (y),
    .g (bg),
    .p (bp)
  );

  assign bg_wide = {{PADW{1'b0}}, bg};
  assign bp_wide = {{PADW{1'b0}}, bp};

  for (genvar i = 0; i < BW; i++) begin : g_carry
    if (i == 0) begin : g_first
      assign bc[i] = cin;
    end else begin : g_rest
      assign bc[i] = la_carry(bg_wide, bp_wide, cin, i);
    end
  end

  assign s     = bp ^ bc;
  assign grp_g = la_carry(bg_wide, bp_wide, 1'b0, BW);
  assign grp_p = &bp;

endmodule

// File: rtl/lah_level2.sv
module lah_level2 #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] grp_g,
  input  logic [N-1:0] grp_p,
  input  logic         cin,
  output logic [N:0]   seam
);
  import lah_pkg::*;

  localparam int unsigned PADN = lah_pkg::LA_MAXW - N;

  logic [lah_pkg::LA_MAXW-1:0] gg_wide;
  logic [lah_pkg::LA_MAXW-1:0] gp_wide;

  assign gg_wide = {{PADN{1'b0}}, grp_g};
  assign gp_wide = {{PADN{1'b0}}, grp_p};

  assign seam[0] = cin;
  for (genvar k = 1; k <= N; k++) begin : g_seam
    assign seam[k] = la_carry(gg_wide, gp_wide, cin, k);
  end

endmodule

// File: rtl/lah_adder.sv
module lah_adder #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned BLK   = 8
) (
  input  logic [WIDTH-1:0]          op_a,
  input  logic [WIDTH-1:0]          op_b,
  input  logic                      carry_in,
  output logic [WIDTH-1:0]          sum,
  output logic                      carry_out,
  output logic [WIDTH/BLK-2:0]      seam_carry
);
  localparam int unsigned NBLK = WIDTH / BLK;

  logic [NBLK-1:0] blk_g;
  logic [NBLK-1:0] blk_p;
  logic [NBLK:0]   blk_cin;

  for (genvar k = 0; k < NBLK; k++) begin : g_slice
    lah_block #(.BW(BLK)) u_blk (
      .x     (op_a[k*BLK +: BLK]),
      .y     (op_b[k*BLK +: BLK]),
      .cin   (blk_cin[k]),
      .s     (sum[k*BLK +: BLK]),
      .grp_g (blk_g[k]),
      .grp_p (blk_p[k])
    );
  end

  lah_level2 #(.N(NBLK)) u_l2 (
    .grp_g (blk_g),
    .grp_p (blk_p),
    .cin   (carry_in),
    .seam  (blk_cin)
  );

  assign carry_out  = blk_cin[NBLK];
  assign seam_carry = blk_cin[NBLK-1:1];

endmodule

// File: rtl/lah_adder_chk.sv
module lah_adder_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned BLK   = 8
) (
  input logic [WIDTH-1:0]     op_a,
  input logic [WIDTH-1:0]     op_b,
  input logic                 carry_in,
  input logic [WIDTH-1:0]     sum,
  input logic                 carry_out,
  input logic [WIDTH/BLK-1:0] blk_g,
  input logic [WIDTH/BLK-1:0] blk_p,
  input logic [WIDTH/BLK:0]   blk_cin
);
  localparam int unsigned NBLK = WIDTH / BLK;

  always_comb begin
    // R1
    sum_value_chk: assert ({carry_out, sum} ==
                           ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}));
    // R7
    if (op_a == '0 && op_b == '0 && !carry_in) begin
      zero_in_chk: assert (sum == '0 && !carry_out);
    end
    for (int k = 0; k < NBLK; k++) begin
      // R3
      seam_chain_chk: assert (blk_cin[k+1] == (blk_g[k] | (blk_p[k] & blk_cin[k])));
      // R8
      if (blk_p[k]) begin
        pass_through_chk: assert (blk_cin[k+1] == blk_cin[k]);
      end
      // R9
      if (blk_g[k]) begin
        own_generate_chk: assert (blk_cin[k+1]);
      end
    end
  end

endmodule

bind lah_adder lah_adder_chk #(.WIDTH(WIDTH), .BLK(BLK)) u_chk (
  .op_a      (op_a),
  .op_b      (op_b),
  .carry_in  (carry_in),
  .sum       (sum),
  .carry_out (carry_out),
  .blk_g     (blk_g),
  .blk_p     (blk_p),
  .blk_cin   (blk_cin)
);

// File: tb/lah_adder_test.sv
`timescale 1ns/1ps
module lah_adder_test;
  localparam int unsigned WIDTH = 32;
  localparam int unsigned BLK   = 8;
  localparam int unsigned NBLK  = WIDTH / BLK;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [WIDTH-1:0]  a_in;
  logic [WIDTH-1:0]  b_in;
  logic              c_in;
  logic [WIDTH-1:0]  s_out;
  logic              co_out;
  logic [NBLK-2:0]   seam_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  lah_adder #(.WIDTH(WIDTH), .BLK(BLK)) uut (
    .op_a       (a_in),
    .op_b       (b_in),
    .carry_in   (c_in),
    .sum        (s_out),
    .carry_out  (co_out),
    .seam_carry (seam_out)
  );

  task automatic check(input string req, input string what,
                       input longint unsigned got, input longint unsigned exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (a=%h b=%h cin=%0b)",
               req, what, got, exp, a_in, b_in, c_in);
    end
  endtask

  // Drive on the falling edge, sample 1 ns later: no clock edge between (R4).
  task automatic apply(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                       input logic c);
    longint unsigned full;
    longint unsigned lowsum;
    longint unsigned mask;
    @(negedge clk);
    a_in = a;
    b_in = b;
    c_in = c;
    #1;
    full = longint'(a) + longint'(b) + longint'(c);
    check("R1", "sum", longint'(s_out), full & 64'hFFFF_FFFF);
    check("R2", "carry_out", longint'(co_out), (full >> WIDTH) & 64'd1);
    for (int k = 1; k < NBLK; k++) begin
      mask   = (64'd1 << (k*BLK)) - 64'd1;
      lowsum = (longint'(a) & mask) + (longint'(b) & mask) + longint'(c);
      check("R3", "seam_carry", longint'(seam_out[k-1]), (lowsum >> (k*BLK)) & 64'd1);
    end
  endtask

  function automatic logic [BLK-1:0] slice_a(input int cls);
    case (cls)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h80;
      default: return 8'h5A;
    endcase
  endfunction

  function automatic logic [BLK-1:0] slice_b(input int cls);
    case (cls)
      0: return 8'h00;
      1: return 8'h00;
      2: return 8'h80;
      default: return 8'h3C;
    endcase
  endfunction

  initial begin
    a_in = '0;
    b_in = '0;
    c_in = 1'b0;

    // R7: all-zero inputs, first vector
    apply('0, '0, 1'b0);
    check("R7", "zero sum", longint'(s_out), 0);
    check("R7", "zero seams", longint'(seam_out), 0);

    // R5: every bit propagates, carry-in set
    apply(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b1);
    check("R5", "sum", longint'(s_out), 0);
    check("R5", "carry_out", longint'(co_out), 1);
    check("R5", "seams", longint'(seam_out), 7);

    // R6: generate only in the top bit
    apply(32'h8000_0000, 32'h8000_0000, 1'b0);
    check("R6", "sum", longint'(s_out), 0);
    check("R6", "carry_out", longint'(co_out), 1);
    check("R6", "seams", longint'(seam_out), 0);

    // R8: slices 1..3 pass the carry generated in slice 0
    apply(32'hFFFF_FF80, 32'h0000_0080, 1'b0);
    check("R8", "seams", longint'(seam_out), 7);
    check("R8", "carry_out", longint'(co_out), 1);

    // R9: slice 2 generates on its own while slice 1 kills
    apply(32'h00FF_0000, 32'h0001_0000, 1'b0);
    check("R9", "seams", longint'(seam_out), 3'b100);

    // Class sweep: all 4^4 slice patterns under both carry-in values
    for (int ci = 0; ci < 2; ci++) begin
      for (int code = 0; code < 256; code++) begin
        logic [WIDTH-1:0] va;
        logic [WIDTH-1:0] vb;
        for (int k = 0; k < NBLK; k++) begin
          va[k*BLK +: BLK] = slice_a((code >> (2*k)) & 3);
          vb[k*BLK +: BLK] = slice_b((code >> (2*k)) & 3);
        end
        apply(va, vb, ci[0]);
      end
    end

    // Random vectors
    for (int n = 0; n < 2000; n++) begin
      apply($urandom, $urandom, 1'($urandom));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule